// File: doc/BRIEF.md
# Next-Instruction Address Unit

This unit holds the program counter of a 32-bit, word-addressed instruction stream. Every cycle it works out where the following instruction lives, using the instruction word that is currently being executed. Four flows are covered. Plain code falls through to the next word. Two conditional branches move by a signed word count measured from the fall-through address. Two absolute jumps keep the current 256 MB region of the PC and replace the rest of the address. A register-indirect jump takes the address directly from a register value.

The register comparison is done by an external comparator, which drives a single equality flag into this unit. The register file supplies the value for the register-indirect jump. The unit also exposes the fall-through address as a link value, which a call instruction writes to its return register. Branch delay slots are not modelled. The PC loads the value on `pc_next` at the end of every enabled cycle.

Top module: `pc_sequencer`

## Requirements
- R1: Holding `rst_n` low at a rising clock edge loads `pc_q` with 0x0040_0000 at that edge, whatever `step_en` is.
- R2: With `rst_n` high and `step_en` low, `pc_q` keeps its value. With `step_en` high, `pc_q` takes the value that `pc_next` showed before the edge.
- R3: The opcode is `instr_word[31:26]` and the funct field is `instr_word[5:0]`. For any opcode other than 0, 2, 3, 4 or 5, and for opcode 0 with a funct other than 8, `pc_next` equals `pc_q + 4`.
- R4: Opcode 4 (branch-if-equal): if `operands_equal` is 1, `pc_next` = `pc_q + 4 + sext(instr_word[15:0]) * 4`. If the flag is 0, `pc_next` = `pc_q + 4`.
- R5: Opcode 5 (branch-if-not-equal): if `operands_equal` is 0, `pc_next` = `pc_q + 4 + sext(instr_word[15:0]) * 4`. If the flag is 1, `pc_next` = `pc_q + 4`.
- R6: Opcodes 2 and 3 (jump, jump-and-link) set `pc_next` = {`pc_q[31:28]`, `instr_word[25:0]`, 2'b00}. Neither the equality flag nor `reg_target` has any effect on the result.
- R7: Opcode 0 with funct 8 (register jump) sets `pc_next` = `reg_target`, exactly as given, whatever the equality flag is.
- R8: `link_addr` always equals `pc_q + 4`.
- R9: All address sums wrap modulo 2^32. Both fall-through from 0xFFFF_FFFC and backward branches past zero wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the PC this cycle |
| instr_word | input | 32 | Instruction at the current PC |
| operands_equal | input | 1 | Equality flag from the external register comparator |
| reg_target | input | 32 | Register value used by the register jump |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address of the following instruction |
| link_addr | output | 32 | Return address (PC + 4) |

## Verification
Both branches are driven with the flag in each polarity. A design with the polarity swapped, or with the offset added to the PC instead of to PC + 4, misses the expected address by four bytes or lands on the wrong target. Jumps are run from a PC whose top nibble is nonzero, so a target that drops the region bits or keeps the wrong ones shows up right away. The wrap cases, fall-through from the last word and a backward branch from address zero, would expose any arithmetic narrower than 32 bits or any saturation. A register-jump funct that differs only in value from an ordinary R-format funct checks that opcode 0 is not treated as a jump by itself.

// File: rtl/npc_pkg.sv
// Package: shared encodings and the flow selector type for the next-PC unit.
// Assumes 32-bit instruction words with the opcode in the top six bits.
package npc_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;
    localparam int INDEX_W = 26;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OP_CALL    = 6'd3;
    localparam logic [OP_W-1:0] OP_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OP_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_REGJUMP = 6'd8;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_ABS    = 2'd2,
        FLOW_REG    = 2'd3
    } flow_e;
endpackage

// File: rtl/npc_decode.sv
// Module: classifies an instruction into one of four address flows.
// Assumes the equality flag is valid in the same cycle as the instruction.
module npc_decode
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    input  logic            equal_flag,
    output flow_e           flow
);
    // Pick the flow from opcode, funct and the branch condition.
    always_comb begin
        flow = FLOW_SEQ;
        case (opcode)
            OP_JUMP, OP_CALL: flow = FLOW_ABS;
            OP_BR_EQ:         flow = equal_flag  ? FLOW_BRANCH : FLOW_SEQ;
            OP_BR_NE:         flow = !equal_flag ? FLOW_BRANCH : FLOW_SEQ;
            OP_SPECIAL:       flow = (funct == FN_REGJUMP) ? FLOW_REG : FLOW_SEQ;
            default:          flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
// Module: forms the fall-through, branch and region-jump candidate addresses.
// Assumes ADDR_W leaves room for the word index plus two zero bits.
module npc_targets
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  pc,
    input  logic [INDEX_W-1:0] index_field,
    output logic [ADDR_W-1:0]  seq_addr,
    output logic [ADDR_W-1:0]  branch_addr,
    output logic [ADDR_W-1:0]  jump_addr
);
    localparam int REGION_W = ADDR_W - INDEX_W - 2;
    localparam int EXT_W    = ADDR_W - IMM_W - 2;

    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] byte_offset;

    // Fall-through address and the sign-extended, word-scaled branch offset.
    always_comb begin
        imm         = index_field[IMM_W-1:0];
        seq_addr    = pc + ADDR_W'(4);
        byte_offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        branch_addr = seq_addr + byte_offset;
    end

    // Region jump: keep the upper PC bits, splice in the word index.
    always_comb begin
        jump_addr = {pc[ADDR_W-1 -: REGION_W], index_field, 2'b00};
    end
endmodule

// File: rtl/npc_pc_reg.sv
// Module: program counter register with synchronous active-low reset and enable.
// Assumes reset takes priority over the enable.
module npc_pc_reg #(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Load the reset address, or advance when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RESET_ADDR;
        else if (en) q <= d;
    end
endmodule

// File: rtl/pc_sequencer.sv
// Module: next-instruction address unit. It holds the PC and selects the
// following address from sequential, branch, region-jump or register-jump flows.
// Assumes the comparator and the register read are settled within the cycle.
module pc_sequencer
    import npc_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0040_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [INSTR_W-1:0]  instr_word,
    input  logic                operands_equal,
    input  logic [ADDR_W-1:0]   reg_target,
    output logic [ADDR_W-1:0]   pc_q,
    output logic [ADDR_W-1:0]   pc_next,
    output logic [ADDR_W-1:0]   link_addr
);
    flow_e             flow;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] branch_addr;
    logic [ADDR_W-1:0] jump_addr;

    npc_decode u_decode (
        .opcode     (instr_word[INSTR_W-1 -: OP_W]),
        .funct      (instr_word[FN_W-1:0]),
        .equal_flag (operands_equal),
        .flow       (flow)
    );

    npc_targets #(.ADDR_W(ADDR_W)) u_targets (
        .pc          (pc_q),
        .index_field (instr_word[INDEX_W-1:0]),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr)
    );

    // Select the following address according to the decoded flow.
    always_comb begin
        case (flow)
            FLOW_BRANCH: pc_next = branch_addr;
            FLOW_ABS:    pc_next = jump_addr;
            FLOW_REG:    pc_next = reg_target;
            default:     pc_next = seq_addr;
        endcase
    end

    // The return address is always the fall-through word.
    always_comb begin
        link_addr = seq_addr;
    end

    npc_pc_reg #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (step_en),
        .d     (pc_next),
        .q     (pc_q)
    );
endmodule

// File: rtl/pc_sequencer_chk.sv
// Module: property checker for pc_sequencer, attached by bind.
// Assumes the ports match the top module by name.
module pc_sequencer_chk #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0040_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic [31:0]       instr_word,
    input logic              operands_equal,
    input logic [ADDR_W-1:0] reg_target,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] pc_next,
    input logic [ADDR_W-1:0] link_addr
);
    logic [5:0] op;
    logic       is_other;
    assign op       = instr_word[31:26];
    assign is_other = (op != 6'd0) && (op != 6'd2) && (op != 6'd3)
                      && (op != 6'd4) && (op != 6'd5);

    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> pc_q == RESET_ADDR);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pc_q));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> pc_q == $past(pc_next));

    assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_other |-> pc_next == link_addr);

    assert_beq_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd4 && !operands_equal) |-> pc_next == link_addr);

    assert_bne_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd5 && operands_equal) |-> pc_next == link_addr);

    assert_region_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd2 || op == 6'd3) |->
            (pc_next[ADDR_W-1 -: 4] == pc_q[ADDR_W-1 -: 4] && pc_next[1:0] == 2'b00));

    assert_regjump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'd0 && instr_word[5:0] == 6'd8) |-> pc_next == reg_target);
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_chk (.*);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] instr_word = 32'h0;
    logic        operands_equal = 1'b0;
    logic [31:0] reg_target = 32'h0;
    logic [31:0] pc_q, pc_next, link_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] model_pc;
    bit          model_valid = 1'b0;
    bit          prev_reset  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr_word(instr_word),
        .operands_equal(operands_equal), .reg_target(reg_target),
        .pc_q(pc_q), .pc_next(pc_next), .link_addr(link_addr)
    );

    function automatic logic [31:0] mk_i(int op, int imm);
        return {6'(op), 5'd9, 5'd0, 16'(imm)};
    endfunction
    function automatic logic [31:0] mk_j(int op, logic [25:0] idx);
        return {6'(op), idx};
    endfunction
    function automatic logic [31:0] mk_r(int fn);
        return {6'd0, 5'd31, 5'd0, 5'd0, 5'd0, 6'(fn)};
    endfunction

    // Behavioural reference for the following address.
    function automatic logic [31:0] ref_next(logic [31:0] pc, logic [31:0] ins,
                                             logic eq, logic [31:0] rv);
        int unsigned op = ins[31:26];
        longint off = longint'($signed(ins[15:0])) * 4;
        logic [31:0] fall = 32'(longint'(pc) + 4);
        logic [31:0] tgt  = 32'(longint'(fall) + off);
        if (op == 2 || op == 3) return (pc & 32'hF000_0000) | (32'(ins[25:0]) * 4);
        if (op == 4) return eq ? tgt : fall;
        if (op == 5) return eq ? fall : tgt;
        if (op == 0 && ins[5:0] == 6'd8) return rv;
        return fall;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, compare all outputs with the model, advance the model.
    task automatic step(bit rst, bit en, logic [31:0] ins, bit eq,
                        logic [31:0] rv, string ntag);
        logic [31:0] exp_next;
        @(negedge clk);
        rst_n = rst; step_en = en; instr_word = ins;
        operands_equal = eq; reg_target = rv;
        #1;
        if (model_valid) begin
            check(prev_reset ? "R1" : "R2", pc_q, model_pc);
            exp_next = ref_next(model_pc, ins, eq, rv);
            if (rst) begin
                check(ntag, pc_next, exp_next);
                check("R8", link_addr, model_pc + 32'd4);
            end else begin
                check(ntag, pc_next, exp_next);
                check("R8", link_addr, model_pc + 32'd4);
            end
        end
        if (!rst) begin
            model_pc = 32'h0040_0000; model_valid = 1'b1;
        end else if (en && model_valid) begin
            model_pc = ref_next(model_pc, ins, eq, rv);
        end
        prev_reset = !rst;
    endtask

    initial begin
        step(0, 0, 32'h0, 0, 32'h0, "R1");
        step(0, 1, 32'h0, 0, 32'h0, "R1");
        step(1, 1, mk_i(8, -50), 0, 32'h0, "R3");           // plain immediate op
        step(1, 1, mk_i(4, 3), 1, 32'h0, "R4");              // beq taken
        step(1, 1, mk_i(4, 3), 0, 32'h0, "R4");              // beq not taken
        step(1, 1, mk_i(5, -2), 0, 32'h0, "R5");             // bne taken, backward
        step(1, 1, mk_i(5, 7), 1, 32'h0, "R5");              // bne not taken
        step(1, 0, mk_j(2, 26'h10_0009), 0, 32'h0, "R6");    // hold (R2 on next pc_q)
        step(1, 1, mk_j(2, 26'h10_0001), 1, 32'h1234_5678, "R6");
        step(1, 1, mk_j(3, 26'h10_0040), 0, 32'h0, "R6");
        step(1, 1, mk_r(32), 0, 32'hDEAD_BEE0, "R3");        // add-type, not a jump
        step(1, 1, mk_r(8), 1, 32'hA000_0100, "R7");
        step(1, 1, mk_j(2, 26'h3FF_FFFF), 1, 32'h0, "R6");   // region bits kept
        step(1, 1, mk_r(8), 0, 32'hFFFF_FFFC, "R7");
        step(1, 1, mk_i(35, 4), 0, 32'h0, "R9");             // wrap to zero
        step(1, 1, mk_i(4, -4), 1, 32'h0, "R9");             // backward past zero
        step(1, 0, mk_i(8, 1), 0, 32'h0, "R3");
        step(1, 1, mk_i(5, 16'h7FFF), 0, 32'h0, "R9");       // max forward offset
        step(0, 1, mk_r(8), 0, 32'h0000_0040, "R7");         // reset wins over enable
        step(1, 1, mk_i(4, 1), 1, 32'h0, "R4");
        step(1, 1, mk_i(8, 0), 0, 32'h0, "R3");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule